// File: doc/BRIEF.md
# Display Rail Power Sequencer

This block brings up and takes down the three supplies of a micromirror display array: an offset rail, a bias rail and a reset rail. It works synchronously to a system clock and measures every delay by counting pulses of a one-millisecond tick input. The supply must first prove stable for a qualification period. After that, raising the projector-enable input starts power-up. The controller first requests display initialization. After a short wait it turns on the offset rail. After a long gap it turns on the bias and reset rails together.

Downstream logic asks for illumination and strobe decoding through two request inputs. The block passes those requests on only while all three rails are up. When projector-enable falls, the bias and reset rails drop first and the offset rail follows after a delay. A fault reported by any rail drops all three enables at once and pulses a discharge output. It also latches a fault flag that blocks further power-up until projector-enable is released. A small register-write port stands in for the serial control interface and holds the display-enable bit.

Top module: `rail_seq_top`

## Requirements
- R1: After reset the state code is OFF, all three rail enables, the discharge pulse, the init request, the fault flag and the display-enable bit are low.
- R2: From OFF the state code becomes STANDBY at the T_SUP-th tick counted while supply_ok stays high, and not before. Whenever supply_ok is low, the next cycle shows OFF with all rail enables low, and the supply tick count restarts.
- R3: In STANDBY with proj_en high and the fault flag clear, the next cycle shows ACTIVE1 with init_req high. The offset enable rises at the T_OFS-th following tick.
- R4: The bias and reset enables rise together at the T_BR-th tick after the offset enable rose, and the state code becomes ACTIVE2. The offset enable is high whenever bias is high.
- R5: illum_en equals illum_req and strobe_en equals strobe_req while all three rail enables are high. Both are low otherwise.
- R6: When proj_en is low during ACTIVE2, the next cycle shows bias and reset low, offset still high and ACTIVE1. Offset falls and the state code becomes STANDBY at the T_DN-th following tick.
- R7: When proj_en is low before ACTIVE2, the power-down path of R6 is taken. If the offset rail was not yet on, it stays off.
- R8: Any rail_fault bit high while sequencing (ACTIVE1 or ACTIVE2) gives, on the next cycle, all three enables low, STANDBY, and a discharge pulse exactly one cycle wide.
- R9: After a fault the fault flag stays high and proj_en high does not restart power-up. proj_en low clears the flag, and a later proj_en high restarts power-up.
- R10: A write with reg_addr equal to 0x01 loads disp_en from reg_wdata bit 0. Writes to any other address leave disp_en unchanged.
- R11: The state code is OFF=0, STANDBY=1, ACTIVE1=2, ACTIVE2=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| supply_ok | input | 1 | System supply present |
| proj_en | input | 1 | Projector enable |
| rail_fault | input | 3 | Fault per rail: bit0 offset, bit1 bias, bit2 reset |
| illum_req | input | 1 | Illumination driver enable request |
| strobe_req | input | 1 | Strobe decoder enable request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| en_ofs | output | 1 | Offset rail enable |
| en_bias | output | 1 | Bias rail enable |
| en_rst | output | 1 | Reset rail enable |
| init_req | output | 1 | Display initialization request |
| discharge | output | 1 | Fast discharge pulse |
| illum_en | output | 1 | Gated illumination driver enable |
| strobe_en | output | 1 | Gated strobe decoder enable |
| disp_en | output | 1 | Display enable register bit |
| fault_flag | output | 1 | Sticky fault flag |
| state_code | output | 2 | Reported power state |

## Verification
Every state, rail and flag output is registered. Each changes at the clock edge that samples the causing input or tick, so it is due one cycle after the stimulus. The gated enables follow their requests in the same cycle. The bench changes inputs after a falling edge and reads outputs at the next falling edge, one edge after the decision. It counts ticks arithmetically and checks before and at the T-th tick of each phase. It injects every fault bit into every sequencing phase.

// File: rtl/rail_seq_pkg.sv
// Shared types for the rail sequencer: internal states and reported codes.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rail_seq_pkg;
    typedef enum logic [2:0] {
        S_OFF, S_STBY, S_INIT, S_RAMP, S_ON, S_DOWN
    } seq_st_e;

    localparam logic [1:0] CODE_OFF  = 2'd0;
    localparam logic [1:0] CODE_STBY = 2'd1;
    localparam logic [1:0] CODE_ACT1 = 2'd2;
    localparam logic [1:0] CODE_ACT2 = 2'd3;

    function automatic logic [1:0] st_code(seq_st_e s);
        case (s)
            S_OFF:   return CODE_OFF;
            S_STBY:  return CODE_STBY;
            S_ON:    return CODE_ACT2;
            default: return CODE_ACT1;
        endcase
    endfunction
endpackage

// File: rtl/rail_seq_timer.sv
// Tick counter for the current phase. It clears when the controller asks
// and otherwise advances once per tick. Assumes tick is one cycle wide.
module rail_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    // Count ticks; clear has priority so a new phase starts at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rail_seq_regif.sv
// Holds the display-enable bit written through a simple write strobe.
// Assumes single-cycle writes; address and bit position are parameters.
module rail_seq_regif #(
    parameter int         AW   = 8,
    parameter int         DW   = 8,
    parameter logic [7:0] ADDR = 8'h01,
    parameter int         BITP = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          disp_en
);
    // Load the bit on a write to the matching address only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          disp_en <= 1'b0;
        else if (wr && addr == AW'(ADDR))    disp_en <= wdata[BITP];
    end

    assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != AW'(ADDR)) |=> $stable(disp_en));
endmodule

// File: rtl/rail_seq_ctrl.sv
// Sequencing state machine: qualifies the supply, staggers the rails,
// runs the ordered shutdown and the fast fault shutdown. Assumes delays
// arrive as tick counts and that the timer restarts on every state change.
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int T_SUP = 5,
    parameter int T_OFS = 5,
    parameter int T_BR  = 145,
    parameter int T_DN  = 10,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          supply_ok,
    input  logic          proj_en,
    input  logic [2:0]    rail_fault,
    input  logic [CW-1:0] cnt,
    output logic          tmr_clr,
    output logic          en_ofs,
    output logic          en_br,
    output logic          init_req,
    output logic          discharge,
    output logic          fault_q,
    output logic [1:0]    code
);
    seq_st_e     st, nxt;
    logic [CW-1:0] lim;
    logic        done, active, fault_hit;

    // Select the tick limit for the current phase.
    always_comb begin
        case (st)
            S_OFF:   lim = CW'(T_SUP - 1);
            S_INIT:  lim = CW'(T_OFS - 1);
            S_RAMP:  lim = CW'(T_BR - 1);
            S_DOWN:  lim = CW'(T_DN - 1);
            default: lim = '0;
        endcase
    end

    assign done      = tick && (cnt == lim);
    assign active    = (st == S_INIT) || (st == S_RAMP) || (st == S_ON) || (st == S_DOWN);
    assign fault_hit = active && (|rail_fault);

    // Next state: supply loss, then fault, then enable release, then timing.
    always_comb begin
        nxt = st;
        if (!supply_ok) nxt = S_OFF;
        else if (fault_hit) nxt = S_STBY;
        else begin
            case (st)
                S_OFF:  if (done) nxt = S_STBY;
                S_STBY: if (proj_en && !fault_q) nxt = S_INIT;
                S_INIT: if (!proj_en) nxt = S_DOWN; else if (done) nxt = S_RAMP;
                S_RAMP: if (!proj_en) nxt = S_DOWN; else if (done) nxt = S_ON;
                S_ON:   if (!proj_en) nxt = S_DOWN;
                S_DOWN: if (done) nxt = S_STBY;
                default: nxt = S_OFF;
            endcase
        end
    end

    // Restart the timer on a state change and while the supply is absent.
    assign tmr_clr = (nxt != st) || (st == S_OFF && !supply_ok);

    // State, rail enables and flags, all registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_OFF;
            en_ofs    <= 1'b0;
            en_br     <= 1'b0;
            init_req  <= 1'b0;
            discharge <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            st        <= nxt;
            en_ofs    <= (nxt == S_RAMP || nxt == S_ON) || (nxt == S_DOWN && en_ofs);
            en_br     <= (nxt == S_ON);
            init_req  <= (nxt == S_INIT);
            discharge <= supply_ok && fault_hit;
            if (supply_ok && fault_hit) fault_q <= 1'b1;
            else if (!proj_en)          fault_q <= 1'b0;
        end
    end

    assign code = st_code(st);

    assert_bias_after_ofs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_br |-> en_ofs);
    assert_fault_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && |rail_fault) |=> (!en_ofs && !en_br));
    assert_disch_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |=> !discharge);
    assert_supply_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (code == CODE_OFF && !en_ofs && !en_br));
    assert_flag_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && supply_ok && code == CODE_STBY) |=> code != CODE_ACT1);
endmodule

// File: rtl/rail_seq_top.sv
// Top of the display rail sequencer: ties timer, controller and register
// together and gates the downstream enables on all rails being up.
// Assumes tick_ms is synchronous to clk and one cycle wide.
module rail_seq_top #(
    parameter int         T_SUP   = 5,
    parameter int         T_OFS   = 5,
    parameter int         T_BR    = 145,
    parameter int         T_DN    = 10,
    parameter logic [7:0] REG_ADR = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       supply_ok,
    input  logic       proj_en,
    input  logic [2:0] rail_fault,
    input  logic       illum_req,
    input  logic       strobe_req,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic       en_ofs,
    output logic       en_bias,
    output logic       en_rst,
    output logic       init_req,
    output logic       discharge,
    output logic       illum_en,
    output logic       strobe_en,
    output logic       disp_en,
    output logic       fault_flag,
    output logic [1:0] state_code
);
    localparam int TM1 = (T_SUP > T_OFS) ? T_SUP : T_OFS;
    localparam int TM2 = (T_BR > T_DN) ? T_BR : T_DN;
    localparam int TMX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW  = $clog2(TMX + 1);

    logic          tmr_clr, en_br, rails_up;
    logic [CW-1:0] cnt;

    rail_seq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick_ms), .cnt(cnt)
    );

    rail_seq_ctrl #(
        .T_SUP(T_SUP), .T_OFS(T_OFS), .T_BR(T_BR), .T_DN(T_DN), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .supply_ok(supply_ok),
        .proj_en(proj_en), .rail_fault(rail_fault), .cnt(cnt),
        .tmr_clr(tmr_clr), .en_ofs(en_ofs), .en_br(en_br),
        .init_req(init_req), .discharge(discharge), .fault_q(fault_flag),
        .code(state_code)
    );

    rail_seq_regif #(.AW(8), .DW(8), .ADDR(REG_ADR), .BITP(0)) u_regif (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .disp_en(disp_en)
    );

    // Bias and reset share one enable so they always rise and fall together.
    assign en_bias  = en_br;
    assign en_rst   = en_br;
    assign rails_up = en_ofs && en_bias && en_rst;

    // Interlock the downstream enables on all three rails.
    assign illum_en  = illum_req && rails_up;
    assign strobe_en = strobe_req && rails_up;
endmodule

// File: tb/rail_seq_top_bench.sv
module rail_seq_top_bench;
    localparam int CLK_P = 10;
    localparam int T_SUP = 3, T_OFS = 2, T_BR = 5, T_DN = 3;

    logic clk = 0, rst_n = 0, tick_ms = 0, supply_ok = 0, proj_en = 0;
    logic [2:0] rail_fault = 0;
    logic illum_req = 0, strobe_req = 0, reg_wr = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0;
    logic en_ofs, en_bias, en_rst, init_req, discharge, illum_en, strobe_en;
    logic disp_en, fault_flag;
    logic [1:0] state_code;
    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    rail_seq_top #(.T_SUP(T_SUP), .T_OFS(T_OFS), .T_BR(T_BR), .T_DN(T_DN)) u_rail_seq_top (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_ok(supply_ok),
        .proj_en(proj_en), .rail_fault(rail_fault), .illum_req(illum_req),
        .strobe_req(strobe_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en_ofs(en_ofs), .en_bias(en_bias), .en_rst(en_rst),
        .init_req(init_req), .discharge(discharge), .illum_en(illum_en),
        .strobe_en(strobe_en), .disp_en(disp_en), .fault_flag(fault_flag),
        .state_code(state_code)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic tick();
        tick_ms = 1; cyc(); tick_ms = 0; cyc();
    endtask

    // rails as a 3-bit word {rst,bias,ofs}
    function automatic int rails();
        return {en_rst, en_bias, en_ofs};
    endfunction

    task automatic to_standby();
        proj_en = 0; rail_fault = 0; supply_ok = 1; cyc();
        for (int k = 0; k < T_SUP + T_OFS + T_BR + T_DN + 2; k++)
            if (state_code != 1) tick();
        chk("R2 standby reached", state_code, 1);
    endtask

    task automatic to_on();
        proj_en = 1; cyc();
        for (int k = 0; k < T_OFS + T_BR; k++) tick();
        chk("R4 on reached", state_code, 3);
    endtask

    initial begin
        cyc(); cyc(); rst_n = 1; cyc();
        // R1 reset state
        chk("R1 state", state_code, 0);
        chk("R1 rails", rails(), 0);
        chk("R1 flags", {discharge, init_req, fault_flag, disp_en}, 0);

        // R2: supply qualification, with a dropout restarting the count
        supply_ok = 1; cyc();
        for (int k = 1; k < T_SUP; k++) tick();
        supply_ok = 0; cyc(); supply_ok = 1; cyc();
        chk("R2 restart", state_code, 0);
        for (int k = 1; k <= T_SUP; k++) begin
            tick();
            chk("R2 qualify", state_code, (k == T_SUP) ? 1 : 0);
        end

        // R3/R4/R5/R11 power-up sweep
        illum_req = 1; strobe_req = 1;
        proj_en = 1; cyc();
        chk("R3 active1", state_code, 2);
        chk("R3 init_req", init_req, 1);
        for (int k = 1; k <= T_OFS; k++) begin
            tick();
            chk("R3 ofs", rails(), (k == T_OFS) ? 1 : 0);
            chk("R5 gate low", {illum_en, strobe_en}, 0);
        end
        for (int k = 1; k <= T_BR; k++) begin
            tick();
            chk("R4 bias/rst", rails(), (k == T_BR) ? 7 : 1);
            chk("R11 code", state_code, (k == T_BR) ? 3 : 2);
        end
        chk("R5 gate high", {illum_en, strobe_en}, 3);
        illum_req = 0; #1;
        chk("R5 follow req", {illum_en, strobe_en}, 1);
        illum_req = 1;

        // R6 normal power-down
        proj_en = 0; cyc();
        chk("R6 bias first", rails(), 1);
        chk("R6 active1", state_code, 2);
        chk("R5 gate drop", {illum_en, strobe_en}, 0);
        for (int k = 1; k <= T_DN; k++) begin
            tick();
            chk("R6 ofs off", rails(), (k == T_DN) ? 0 : 1);
            chk("R6 standby", state_code, (k == T_DN) ? 1 : 2);
        end

        // R7 abort during the offset wait and during the ramp
        for (int ph = 0; ph < 2; ph++) begin
            proj_en = 1; cyc();
            if (ph == 1) for (int k = 0; k < T_OFS; k++) tick();
            proj_en = 0; cyc();
            chk("R7 abort rails", rails(), ph);
            chk("R7 abort code", state_code, 2);
            for (int k = 0; k < T_DN; k++) tick();
            chk("R7 abort end", state_code, 1);
            chk("R7 abort off", rails(), 0);
        end

        // R8/R9 each fault bit in each sequencing phase
        for (int b = 0; b < 3; b++) begin
            for (int ph = 0; ph < 4; ph++) begin
                to_standby();
                proj_en = 1; cyc();
                if (ph >= 1) for (int k = 0; k < T_OFS; k++) tick();
                if (ph >= 2) for (int k = 0; k < T_BR; k++) tick();
                if (ph == 3) begin proj_en = 0; cyc(); end
                rail_fault = 3'(1 << b); cyc(); rail_fault = 0;
                chk("R8 rails off", rails(), 0);
                chk("R8 standby", state_code, 1);
                chk("R8 discharge", discharge, 1);
                cyc();
                chk("R8 pulse width", discharge, 0);
                if (ph < 3) begin
                    chk("R9 flag set", fault_flag, 1);
                    for (int k = 0; k < T_OFS + 1; k++) tick();
                    chk("R9 blocked", state_code, 1);
                    chk("R9 blocked rails", rails(), 0);
                    proj_en = 0; cyc();
                    chk("R9 flag clear", fault_flag, 0);
                    proj_en = 1; cyc();
                    chk("R9 restart", state_code, 2);
                    proj_en = 0; cyc();
                    for (int k = 0; k < T_DN; k++) tick();
                end
            end
        end

        // R2 supply loss while on
        to_standby(); to_on();
        supply_ok = 0; cyc();
        chk("R2 loss state", state_code, 0);
        chk("R2 loss rails", rails(), 0);
        supply_ok = 1; proj_en = 0;

        // R10 register writes: bit0 at 0x01, other addresses ignored
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 2; d++) begin
                logic prev;
                prev = disp_en;
                reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1; cyc(); reg_wr = 0;
                chk("R10 disp_en", disp_en, (a == 1) ? d : prev);
            end
        end
        reg_addr = 8'h01; reg_wdata = 8'hFE; reg_wr = 1; cyc(); reg_wr = 0;
        chk("R10 bit0 only", disp_en, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule